// File: doc/BRIEF.md
# Supply and Watchdog Supervisor Output Controller

This block is the decision logic of a fail-safe supervisor. It watches four digital voltage-fault flags (over- and under-voltage on two supply rails), a power-on indication and a watchdog health flag. From these it drives a complementary pair of reset lines, a complementary pair of enable lines, a gated relay enable and a gated power-switch enable. It also supplies a clear pulse that returns the watchdog to its initial state.

A voltage fault counts only once it has been present for a programmable number of clock ticks. A fault that qualifies holds the system in reset. The reset stays in force for a programmable delay after the last qualified fault or the end of power-on. A fault that qualifies again during that delay restarts the full delay. The outputs follow a fixed priority. Reset comes first, and it forces every driver off. The watchdog row comes next: it leaves the reset lines inactive but keeps enables and drivers off. When nothing is wrong, the enables are active and the relay and switch each follow their own request.

All pins are plain level signals sampled on one clock. There is no data stream, so there is no valid/ready handshake and no back-pressure. Every external input except the watchdog flag passes through a synchroniser (SYNC_STAGES flops). Every output comes from a flop.

Top module: `fsup_ctrl`

## Requirements
- R1: A voltage-fault flag that stays high for fewer than DEB_CYC consecutive clocks (after synchronisation) leaves every output unchanged.
- R2: A voltage fault held for L >= DEB_CYC clocks raises the positive reset output DEB_CYC+3 clocks after the fault rises. The output stays high for exactly L-DEB_CYC+1+DELAY_CYC clocks.
- R3: A fault that qualifies while the reset delay is still running restarts the full delay. The reset output stays continuously high until DELAY_CYC clocks after the second fault is debounced away. A second fault that is too short to qualify does not lengthen the reset.
- R4: The power-on input acts without debounce. The reset output goes high 3 clocks after power-on rises and stays high until DELAY_CYC clocks after power-on falls, a total of L+DELAY_CYC clocks for a power-on of L clocks.
- R5: While reset is active, the outputs are: positive reset 1, negative reset 0, positive enable 0, negative enable 1, relay 0, switch 0, watchdog clear 1. This holds whatever the watchdog flag and the requests are.
- R6: With reset inactive and the watchdog flag low, both reset outputs are inactive (positive 0, negative 1), the enables are disabled (positive 0, negative 1), and relay and switch are 0.
- R7: With reset inactive and the watchdog flag high, the positive enable is 1 and the negative enable is 0. The relay output equals its request and the switch output equals its own request, independently of each other. A request held low, which is the state of an undriven input, keeps its output off.
- R8: The watchdog clear output is high exactly when the positive reset output is high, including during power-on.
- R9: While rst_n is low, the outputs take the R5 values. After rst_n rises, the reset outputs stay active for DELAY_CYC further clocks.
- R10: Each negative output is always the complement of its positive partner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| por_i | input | 1 | Power-on indication, high while supply is starting |
| rail_a_ov_i | input | 1 | Rail A over-voltage flag |
| rail_a_uv_i | input | 1 | Rail A under-voltage flag |
| rail_b_ov_i | input | 1 | Rail B over-voltage flag |
| rail_b_uv_i | input | 1 | Rail B under-voltage flag |
| wd_ok_i | input | 1 | Watchdog health flag, synchronous to clk |
| relay_req_i | input | 1 | Relay request, high to switch on |
| fet_req_i | input | 1 | Power-switch request, high to switch on |
| rst_hi_o | output | 1 | Reset, active high |
| rst_lo_o | output | 1 | Reset, active low |
| en_hi_o | output | 1 | Enable, active high |
| en_lo_o | output | 1 | Enable, active low |
| relay_on_o | output | 1 | Gated relay drive |
| fet_on_o | output | 1 | Gated power-switch drive |
| wd_clr_o | output | 1 | Clear to the watchdog, high to hold it in its initial state |

## Verification
A wrong debounce count moves the rising edge of the reset output away from DEB_CYC+3 clocks. It also lets a pulse one clock too short through, or blocks one that is just long enough, and the next edge of the reset output shows this. A delay counter that loads or decrements wrongly changes the reset width by whole clocks, and the first falling edge shows it. A missed restart on a second qualified fault shows up as an early release or as a gap in the reset output. An error in the priority mapping shows within one clock as an enable or driver that is on during a reset or watchdog row, or as a pair that is no longer complementary.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  // Registered pin bundle; every field is its own flop.
  typedef struct packed {
    logic rst_hi;
    logic rst_lo;
    logic en_hi;
    logic en_lo;
    logic relay;
    logic fet;
    logic wd_clr;
  } drv_t;

  // Safe state: reset asserted, all drivers off, watchdog held.
  localparam drv_t DRV_SAFE = '{rst_hi: 1'b1, rst_lo: 1'b0, en_hi: 1'b0,
                                en_lo: 1'b1, relay: 1'b0, fet: 1'b0,
                                wd_clr: 1'b1};

  // Watchdog row: reset released, enables and drivers off.
  localparam drv_t DRV_WDBAD = '{rst_hi: 1'b0, rst_lo: 1'b1, en_hi: 1'b0,
                                 en_lo: 1'b1, relay: 1'b0, fet: 1'b0,
                                 wd_clr: 1'b0};

  // Number of voltage-fault flags handled.
  localparam int unsigned N_FLT = 4;

endpackage

// File: rtl/fsup_sync.sv
module fsup_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh_q[STAGES-1];
  end

endmodule

// File: rtl/fsup_debounce.sv
module fsup_debounce #(
  parameter int unsigned DEB_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flt_i,
  output logic flt_o
);

  localparam int unsigned CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] TOP = CW'(DEB_CYC);

  logic [CW-1:0] cnt_q;

  // Count consecutive fault samples, saturating at the threshold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!flt_i)       cnt_q <= '0;
    else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign flt_o = (cnt_q == TOP);

  // R1: qualification only after the input was high on the previous edge
  a_r1_rise_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_o) |-> $past(flt_i));

  // R1: a single low sample drops qualification
  a_r1_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_i |=> !flt_o);

endmodule

// File: rtl/fsup_delay.sv
module fsup_delay #(
  parameter int unsigned DELAY_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  output logic act_o
);

  localparam int unsigned CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(DELAY_CYC);

  logic [CW-1:0] cnt_q;

  // Any hold reloads the full delay; otherwise count down to zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= FULL;
    else if (hold_i)        cnt_q <= FULL;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign act_o = hold_i | (cnt_q != '0);

  // R3: every hold restarts a full delay
  a_r3_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == FULL));

  // R2: free-running delay drops by one per clock
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fsup_outmap.sv
module fsup_outmap
  import fsup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic wd_ok_i,
  input  logic relay_req_i,
  input  logic fet_req_i,
  output drv_t drv_o
);

  drv_t nxt;

  // Fixed priority: reset row, then watchdog row, then normal operation.
  always_comb begin
    if (act_i) begin
      nxt = DRV_SAFE;
    end else if (!wd_ok_i) begin
      nxt = DRV_WDBAD;
    end else begin
      nxt        = DRV_WDBAD;
      nxt.en_hi  = 1'b1;
      nxt.en_lo  = 1'b0;
      nxt.relay  = relay_req_i;
      nxt.fet    = fet_req_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_o <= DRV_SAFE;
    else        drv_o <= nxt;
  end

  // R5: reset row forces the safe pattern
  a_r5_reset_row: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> (drv_o.rst_hi && !drv_o.rst_lo && !drv_o.en_hi && drv_o.en_lo
               && !drv_o.relay && !drv_o.fet && drv_o.wd_clr));

  // R6: watchdog row keeps enables and drivers off, reset released
  a_r6_wd_row: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_i && !wd_ok_i) |=> (!drv_o.rst_hi && !drv_o.en_hi
                              && !drv_o.relay && !drv_o.fet));

  // R7: a driver is never on without its request
  a_r7_relay_gated: assert property (@(posedge clk) disable iff (!rst_n)
    drv_o.relay |-> $past(relay_req_i));

  // R10: complementary pairs
  a_r10_rst_pair: assert property (@(posedge clk) disable iff (!rst_n)
    drv_o.rst_hi != drv_o.rst_lo);
  a_r10_en_pair: assert property (@(posedge clk) disable iff (!rst_n)
    drv_o.en_hi != drv_o.en_lo);

  // R8: watchdog clear tracks reset
  a_r8_clear_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    drv_o.wd_clr == drv_o.rst_hi);

endmodule

// File: rtl/fsup_ctrl.sv
module fsup_ctrl
  import fsup_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_CYC     = 4,
  parameter int unsigned DELAY_CYC   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_i,
  input  logic rail_a_ov_i,
  input  logic rail_a_uv_i,
  input  logic rail_b_ov_i,
  input  logic rail_b_uv_i,
  input  logic wd_ok_i,
  input  logic relay_req_i,
  input  logic fet_req_i,
  output logic rst_hi_o,
  output logic rst_lo_o,
  output logic en_hi_o,
  output logic en_lo_o,
  output logic relay_on_o,
  output logic fet_on_o,
  output logic wd_clr_o
);

  // Synchronised bundle: [3:0] fault flags, [4] power-on, [5] relay, [6] fet
  localparam int unsigned NSYNC = N_FLT + 3;

  logic [NSYNC-1:0] raw, syn;
  logic             any_flt, flt_q, hold, act;
  drv_t             drv;

  assign raw = {fet_req_i, relay_req_i, por_i,
                rail_b_uv_i, rail_b_ov_i, rail_a_uv_i, rail_a_ov_i};

  fsup_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .d_i (raw), .q_o (syn)
  );

  assign any_flt = |syn[N_FLT-1:0];

  fsup_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk (clk), .rst_n (rst_n), .flt_i (any_flt), .flt_o (flt_q)
  );

  // Power-on bypasses debounce; both hold the delay at its full value.
  assign hold = flt_q | syn[N_FLT];

  fsup_delay #(.DELAY_CYC(DELAY_CYC)) u_dly (
    .clk (clk), .rst_n (rst_n), .hold_i (hold), .act_o (act)
  );

  fsup_outmap u_map (
    .clk (clk), .rst_n (rst_n), .act_i (act), .wd_ok_i (wd_ok_i),
    .relay_req_i (syn[N_FLT+1]), .fet_req_i (syn[N_FLT+2]), .drv_o (drv)
  );

  assign rst_hi_o   = drv.rst_hi;
  assign rst_lo_o   = drv.rst_lo;
  assign en_hi_o    = drv.en_hi;
  assign en_lo_o    = drv.en_lo;
  assign relay_on_o = drv.relay;
  assign fet_on_o   = drv.fet;
  assign wd_clr_o   = drv.wd_clr;

  // R4: power-on held through synchroniser forces reset on the next edge
  a_r4_por_forces: assert property (@(posedge clk) disable iff (!rst_n)
    syn[N_FLT] |=> rst_hi_o);

endmodule

// File: tb/fsup_ctrl_tb.sv
module fsup_ctrl_tb;

  localparam int DEB = 4;
  localparam int DLY = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por = 1'b0;
  logic [3:0] flt = '0;
  logic wd_ok = 1'b0, rel_req = 1'b0, fet_req = 1'b0;
  logic rst_hi_o, rst_lo_o, en_hi_o, en_lo_o, relay_on_o, fet_on_o, wd_clr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fsup_ctrl #(.SYNC_STAGES(2), .DEB_CYC(DEB), .DELAY_CYC(DLY)) u_dut (
    .clk (clk), .rst_n (rst_n), .por_i (por),
    .rail_a_ov_i (flt[0]), .rail_a_uv_i (flt[1]),
    .rail_b_ov_i (flt[2]), .rail_b_uv_i (flt[3]),
    .wd_ok_i (wd_ok), .relay_req_i (rel_req), .fet_req_i (fet_req),
    .rst_hi_o (rst_hi_o), .rst_lo_o (rst_lo_o), .en_hi_o (en_hi_o),
    .en_lo_o (en_lo_o), .relay_on_o (relay_on_o), .fet_on_o (fet_on_o),
    .wd_clr_o (wd_clr_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int safe_pat();
    return {rst_hi_o, rst_lo_o, en_hi_o, en_lo_o, relay_on_o, fet_on_o, wd_clr_o};
  endfunction

  // Drive a fault (or power-on) pattern and measure the reset window.
  task automatic run_seq(input int idx, input bit use_por, input int l1,
                         input int r2, input int l2, input int fexp,
                         input int lexp, input string req);
    int first = -1, last = -1, highs = 0, rowbad = 0;
    for (int n = 0; n < 60; n++) begin
      bit drv;
      @(negedge clk);
      if (rst_hi_o) begin
        if (first < 0) first = n;
        last = n;
        highs++;
        if (safe_pat() != 7'b1001001) rowbad++;
      end
      if (rst_lo_o == rst_hi_o || en_lo_o == en_hi_o || wd_clr_o != rst_hi_o) rowbad++;
      drv = (n < l1) || (r2 > 0 && n >= r2 && n < r2 + l2);
      if (use_por) por = drv;
      else         flt[idx] = drv;
    end
    check(first == fexp, {req, " reset start"}, first, fexp);
    check(last == lexp, {req, " reset end"}, last, lexp);
    if (first >= 0)
      check(highs == last - first + 1, {req, " reset contiguous"}, highs, last - first + 1);
    check(rowbad == 0, "R5/R8/R10 pattern during run", rowbad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int last;
    wd_ok = 1'b1; rel_req = 1'b1; fet_req = 1'b1;
    // R9: reset state with requests active
    repeat (3) @(negedge clk);
    check(safe_pat() == 7'b1001001, "R9 reset state", safe_pat(), 7'b1001001);
    rst_n = 1'b1;
    last = 0;
    for (int n = 1; n < 40; n++) begin
      @(negedge clk);
      if (rst_hi_o) last = n;
    end
    check(last == DLY, "R9 delay after rst_n", last, DLY);

    // R1/R2: sweep pulse length on every flag
    for (int f = 0; f < 4; f++) begin
      for (int l = 1; l <= 8; l++) begin
        if (l < DEB) run_seq(f, 1'b0, l, 0, 0, -1, -1, "R1 short fault");
        else         run_seq(f, 1'b0, l, 0, 0, 3 + DEB, l + 3 + DLY, "R2 long fault");
      end
    end

    // R3: qualified second fault during the delay restarts it
    run_seq(2, 1'b0, DEB + 1, DEB + 4, DEB, 3 + DEB, (DEB + 4) + DEB + 3 + DLY, "R3 retrigger");
    run_seq(0, 1'b0, DEB, DEB + 6, DEB + 3, 3 + DEB, (DEB + 6) + DEB + 3 + 3 + DLY, "R3 retrigger late");
    // R3: short second fault does not extend
    run_seq(1, 1'b0, DEB + 1, DEB + 4, DEB - 1, 3 + DEB, DEB + 1 + 3 + DLY, "R3 short second");

    // R4 / R8: power-on, no debounce
    for (int l = 1; l <= 5; l += 2)
      run_seq(0, 1'b1, l, 0, 0, 3, l + 2 + DLY, "R4 power-on");

    // R6 / R7: truth table sweep in steady state
    for (int c = 0; c < 8; c++) begin
      int got, exp;
      wd_ok = c[2]; rel_req = c[1]; fet_req = c[0];
      repeat (6) @(negedge clk);
      got = safe_pat();
      if (!c[2]) exp = 7'b0101000;
      else       exp = {4'b0110, c[1], c[0], 1'b0};
      check(got == exp, c[2] ? "R7 normal row" : "R6 watchdog row", got, exp);
    end

    // R5: fault with watchdog bad still gives the reset row
    wd_ok = 1'b0;
    run_seq(3, 1'b0, DEB + 2, 0, 0, 3 + DEB, DEB + 2 + 3 + DLY, "R5 reset over watchdog row");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule